// File: doc/BRIEF.md
# Nametable Slot Router with Expansion RAM

This block sits between the picture processor's nametable fetches and the memories that can answer them. The 4 KB nametable window at $2000-$2FFF is split into four 1 KB slots, and a programmable map gives each slot one of four sources. The sources are console nametable RAM page 0, console page 1, a 1 KB expansion RAM held inside the block, or a fill generator that answers with a constant tile byte and a constant attribute. Software can rewrite the map many times per frame. A split-screen effect can then change the slot layout between scanlines.

A separate usage mode controls how the expansion RAM is shared. In the two display modes (0 and 1) the picture processor may read and write it through any slot mapped to it, and CPU reads of the RAM window return zero. In the two plain-RAM modes (2 and 3) the CPU owns it through the window at $5C00-$5FFF, and picture processor reads of it return zero. Mode 3 also blocks CPU writes. Console RAM accesses are not served by the block itself. It drives a chip-enable and a page select toward the console RAM and returns that RAM's data.

Top module: `nt_router`

## Requirements
- R1: A picture processor access with address bits [13:12] = 2'b10 falls in slot `addr[11:10]`. The slot's source is map bits `[2*slot+1 : 2*slot]`: 0 = console page 0, 1 = console page 1, 2 = expansion RAM, 3 = fill. Configuration registers are CPU write-only: $5104 usage mode (bits 1:0), $5105 map, $5106 fill tile byte, $5107 fill attribute (bits 1:0).
- R2: For an access to a console-page slot, `ciram_ce` is high and `ciram_page` equals the page number, in the same cycle. For any other access, and when there is no access, `ciram_ce` and `ciram_page` are low. On a console-page read, `ppu_rdata` presents `ciram_rdata` one cycle after `ppu_rd`.
- R3: A read of a slot mapped to expansion RAM returns the byte at offset `addr[9:0]` one cycle later when the mode is 0 or 1, and returns 0 when the mode is 2 or 3.
- R4: A read of a fill slot returns the fill tile byte at offsets $000-$3BF. At offsets $3C0-$3FF it returns the 2-bit fill attribute copied into all four bit pairs.
- R5: A map or mode write takes effect on the first access after the clock edge that stores it. An access in the same cycle as the write still uses the old value.
- R6: CPU writes to $5C00-$5FFF store into the expansion RAM at `addr[9:0]` in modes 0, 1 and 2, and are ignored in mode 3.
- R7: A CPU read of $5C00-$5FFF returns the stored byte one cycle after `cpu_re` in modes 2 and 3, and returns 0 in modes 0 and 1. CPU reads of any other address return 0.
- R8: A picture processor write to a console-page slot raises `ciram_we`. A write to an expansion RAM slot stores the byte only in modes 0 and 1. Writes to fill slots are ignored.
- R9: Reset clears all four configuration registers: every slot maps to console page 0, the mode is 0, and both read-data outputs are 0.
- R10: When a picture processor write to expansion RAM and a CPU write to the RAM window happen in the same cycle, the picture processor byte is stored and the CPU write is dropped.
- R11: `ppu_rdata` and `cpu_rdata` keep their last value in cycles with no read. A read outside the nametable window returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_re | input | 1 | CPU read strobe |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, one cycle after `cpu_re` |
| ppu_rd | input | 1 | Picture processor read strobe |
| ppu_we | input | 1 | Picture processor write strobe |
| ppu_addr | input | 14 | Picture processor address |
| ppu_wdata | input | 8 | Picture processor write data |
| ppu_rdata | output | 8 | Picture processor read data, one cycle after `ppu_rd` |
| ciram_ce | output | 1 | Console nametable RAM enable |
| ciram_page | output | 1 | Console nametable RAM page select |
| ciram_we | output | 1 | Console nametable RAM write enable |
| ciram_rdata | input | 8 | Data returned by console nametable RAM |

## Verification
The hardest case to reach is a write collision on the expansion RAM. A picture processor write to an expansion-RAM slot and a CPU write into the RAM window must land on the same edge, and this can only happen in a display mode. The result cannot be seen until the mode is switched to a plain-RAM mode and the CPU reads it back. The stimulus therefore runs a fixed sequence for this case: set mode 0, write from both sides at once, switch to mode 2, then read from the CPU. The same-cycle map rewrite of R5 also needs a fixed order: a map write and a read in the same cycle, followed at once by a second read. A long random phase then mixes map, mode and fill rewrites with traffic from both sides. This phase exercises every slot and source against the reference model.

// File: rtl/nt_route_pkg.sv
package nt_route_pkg;
    localparam int SLOT_AW  = 10;
    localparam int DW       = 8;
    localparam int NSLOTS   = 4;
    localparam int ATTR_REP = DW / 2;

    localparam logic [15:0] REG_MODE      = 16'h5104;
    localparam logic [15:0] REG_MAP       = 16'h5105;
    localparam logic [15:0] REG_FILL_TILE = 16'h5106;
    localparam logic [15:0] REG_FILL_ATTR = 16'h5107;
    localparam logic [15:0] XR_BASE       = 16'h5C00;

    typedef enum logic [1:0] {
        SRC_PAGE0 = 2'd0,
        SRC_PAGE1 = 2'd1,
        SRC_EXRAM = 2'd2,
        SRC_FILL  = 2'd3
    } nt_src_e;

    typedef enum logic [1:0] {
        XR_NAMETABLE = 2'd0,
        XR_ATTRIB    = 2'd1,
        XR_RAM       = 2'd2,
        XR_RAM_RO    = 2'd3
    } xr_mode_e;

    typedef struct packed {
        xr_mode_e          mode;
        logic [2*NSLOTS-1:0] map;
        logic [DW-1:0]     fill_tile;
        logic [1:0]        fill_attr;
    } nt_cfg_t;

    function automatic nt_src_e slot_source(input logic [2*NSLOTS-1:0] map, input logic [1:0] slot);
        return nt_src_e'(map[{slot, 1'b0} +: 2]);
    endfunction

    function automatic logic is_attr_ofs(input logic [SLOT_AW-1:0] ofs);
        return ofs[SLOT_AW-1:SLOT_AW-4] == 4'hF;
    endfunction

    function automatic logic xr_display_mode(input xr_mode_e m);
        return (m == XR_NAMETABLE) || (m == XR_ATTRIB);
    endfunction
endpackage

// File: rtl/nt_cfg_regs.sv
module nt_cfg_regs
    import nt_route_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_we,
    input  logic [15:0]   cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output nt_cfg_t       cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (cpu_we) begin
            unique case (cpu_addr)
                REG_MODE:      cfg.mode      <= xr_mode_e'(cpu_wdata[1:0]);
                REG_MAP:       cfg.map       <= cpu_wdata[2*NSLOTS-1:0];
                REG_FILL_TILE: cfg.fill_tile <= cpu_wdata;
                REG_FILL_ATTR: cfg.fill_attr <= cpu_wdata[1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/nt_exram.sv
module nt_exram #(
    parameter int AW = 10,
    parameter int W  = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [W-1:0]  rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/nt_fill_gen.sv
module nt_fill_gen
    import nt_route_pkg::*;
(
    input  logic [DW-1:0]      fill_tile,
    input  logic [1:0]         fill_attr,
    input  logic [SLOT_AW-1:0] ofs,
    output logic [DW-1:0]      fill_byte
);
    logic [DW-1:0] attr_byte;

    for (genvar g = 0; g < ATTR_REP; g++) begin : g_rep
        assign attr_byte[2*g +: 2] = fill_attr;
    end

    assign fill_byte = is_attr_ofs(ofs) ? attr_byte : fill_tile;
endmodule

// File: rtl/nt_router.sv
module nt_router
    import nt_route_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_we,
    input  logic        cpu_re,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    output logic [7:0]  cpu_rdata,
    input  logic        ppu_rd,
    input  logic        ppu_we,
    input  logic [13:0] ppu_addr,
    input  logic [7:0]  ppu_wdata,
    output logic [7:0]  ppu_rdata,
    output logic        ciram_ce,
    output logic        ciram_page,
    output logic        ciram_we,
    input  logic [7:0]  ciram_rdata
);
    nt_cfg_t              cfg;
    logic                 in_win;
    logic [1:0]           slot;
    logic [SLOT_AW-1:0]   ofs;
    nt_src_e              src;
    logic                 ppu_acc;
    logic                 xr_cpu_hit;
    logic                 ppu_xr_we;
    logic                 cpu_xr_we;
    logic                 ram_we;
    logic [SLOT_AW-1:0]   ram_waddr;
    logic [DW-1:0]        ram_wdata;
    logic [DW-1:0]        ram_rd_ppu;
    logic [DW-1:0]        ram_rd_cpu;
    logic [DW-1:0]        fill_byte;
    logic [DW-1:0]        ppu_byte;
    logic [DW-1:0]        cpu_byte;
    logic [DW-1:0]        ppu_rdata_q;
    logic [DW-1:0]        cpu_rdata_q;

    nt_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cfg       (cfg)
    );

    assign in_win  = (ppu_addr[13:12] == 2'b10);
    assign slot    = ppu_addr[11:10];
    assign ofs     = ppu_addr[SLOT_AW-1:0];
    assign src     = slot_source(cfg.map, slot);
    assign ppu_acc = (ppu_rd || ppu_we) && in_win;

    assign ciram_ce   = ppu_acc && ((src == SRC_PAGE0) || (src == SRC_PAGE1));
    assign ciram_page = ciram_ce && (src == SRC_PAGE1);
    assign ciram_we   = ciram_ce && ppu_we;

    assign xr_cpu_hit = (cpu_addr[15:SLOT_AW] == XR_BASE[15:SLOT_AW]);
    assign ppu_xr_we  = ppu_we && in_win && (src == SRC_EXRAM) && xr_display_mode(cfg.mode);
    assign cpu_xr_we  = cpu_we && xr_cpu_hit && (cfg.mode != XR_RAM_RO);

    // Single write port: the picture processor side takes precedence.
    assign ram_we    = ppu_xr_we || cpu_xr_we;
    assign ram_waddr = ppu_xr_we ? ofs : cpu_addr[SLOT_AW-1:0];
    assign ram_wdata = ppu_xr_we ? ppu_wdata : cpu_wdata;

    nt_exram #(.AW(SLOT_AW), .W(DW)) u_ram (
        .clk     (clk),
        .we      (ram_we),
        .waddr   (ram_waddr),
        .wdata   (ram_wdata),
        .raddr_a (ofs),
        .rdata_a (ram_rd_ppu),
        .raddr_b (cpu_addr[SLOT_AW-1:0]),
        .rdata_b (ram_rd_cpu)
    );

    nt_fill_gen u_fill (
        .fill_tile (cfg.fill_tile),
        .fill_attr (cfg.fill_attr),
        .ofs       (ofs),
        .fill_byte (fill_byte)
    );

    always_comb begin
        ppu_byte = '0;
        if (in_win) begin
            unique case (src)
                SRC_PAGE0, SRC_PAGE1: ppu_byte = ciram_rdata;
                SRC_EXRAM:            ppu_byte = xr_display_mode(cfg.mode) ? ram_rd_ppu : '0;
                SRC_FILL:             ppu_byte = fill_byte;
                default:              ppu_byte = '0;
            endcase
        end
    end

    assign cpu_byte = (xr_cpu_hit && !xr_display_mode(cfg.mode)) ? ram_rd_cpu : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ppu_rdata_q <= '0;
            cpu_rdata_q <= '0;
        end else begin
            if (ppu_rd) ppu_rdata_q <= ppu_byte;
            if (cpu_re) cpu_rdata_q <= cpu_byte;
        end
    end

    assign ppu_rdata = ppu_rdata_q;
    assign cpu_rdata = cpu_rdata_q;
endmodule

// File: rtl/nt_router_chk.sv
module nt_router_chk (
    input logic        clk,
    input logic        rst,
    input logic        ppu_rd,
    input logic        ppu_we,
    input logic [13:0] ppu_addr,
    input logic [7:0]  ppu_rdata,
    input logic        cpu_re,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_rdata,
    input logic        ciram_ce,
    input logic        ciram_we,
    input logic [1:0]  xr_mode,
    input logic [7:0]  map,
    input logic [1:0]  fill_attr
);
    logic       win;
    logic [1:0] fld;

    assign win = (ppu_addr[13:12] == 2'b10);

    always_comb begin
        case (ppu_addr[11:10])
            2'd0:    fld = map[1:0];
            2'd1:    fld = map[3:2];
            2'd2:    fld = map[5:4];
            default: fld = map[7:6];
        endcase
    end

    AST_CE_ONLY_ON_ACCESS: assert property (@(posedge clk) disable iff (rst)
        ciram_ce |-> ((ppu_rd || ppu_we) && win)); // R2

    AST_CIRAM_WE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        ciram_we |-> (ppu_we && ciram_ce)); // R8

    AST_CPU_WINDOW_HIDDEN: assert property (@(posedge clk) disable iff (rst)
        (cpu_re && cpu_addr[15:10] == 6'b010111 && xr_mode < 2'd2) |=> (cpu_rdata == 8'h00)); // R7

    AST_PPU_XR_HIDDEN: assert property (@(posedge clk) disable iff (rst)
        (ppu_rd && win && fld == 2'd2 && xr_mode >= 2'd2) |=> (ppu_rdata == 8'h00)); // R3

    AST_FILL_ATTR: assert property (@(posedge clk) disable iff (rst)
        (ppu_rd && win && fld == 2'd3 && ppu_addr[9:6] == 4'hF) |=> (ppu_rdata == {4{$past(fill_attr)}})); // R4

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ppu_rd && !cpu_re) |=> ($stable(ppu_rdata) && $stable(cpu_rdata))); // R11
endmodule

bind nt_router nt_router_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ppu_rd    (ppu_rd),
    .ppu_we    (ppu_we),
    .ppu_addr  (ppu_addr),
    .ppu_rdata (ppu_rdata),
    .cpu_re    (cpu_re),
    .cpu_addr  (cpu_addr),
    .cpu_rdata (cpu_rdata),
    .ciram_ce  (ciram_ce),
    .ciram_we  (ciram_we),
    .xr_mode   (cfg.mode),
    .map       (cfg.map),
    .fill_attr (cfg.fill_attr)
);

// File: tb/sim_nt_router.sv
module sim_nt_router;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_we = 1'b0, cpu_re = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        ppu_rd = 1'b0, ppu_we = 1'b0;
    logic [13:0] ppu_addr = '0;
    logic [7:0]  ppu_wdata = '0;
    logic [7:0]  ppu_rdata;
    logic        ciram_ce, ciram_page, ciram_we;
    logic [7:0]  ciram_rdata = '0;

    always #5 clk = ~clk;

    nt_router u0 (
        .clk(clk), .rst(rst),
        .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .ppu_rd(ppu_rd), .ppu_we(ppu_we), .ppu_addr(ppu_addr),
        .ppu_wdata(ppu_wdata), .ppu_rdata(ppu_rdata),
        .ciram_ce(ciram_ce), .ciram_page(ciram_page), .ciram_we(ciram_we),
        .ciram_rdata(ciram_rdata)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int   ram [1024];
    int   m_mode, m_map, m_ft, m_fa;
    int   e_ppu, e_cpu;
    string e_ppu_tag = "R9";
    string dir_tag = "";

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, dir_tag, act, exp, $time);
        end
    endtask

    // one clock of stimulus; entered and left just after a falling edge
    task automatic cycle(input bit prd, input bit pwe, input int pa, input int pwd,
                         input bit cre, input bit cwe, input int ca, input int cwd);
        int slot, ofs, src, win, cird;
        bit pxw;
        ppu_rd = prd; ppu_we = pwe; ppu_addr = pa[13:0]; ppu_wdata = pwd[7:0];
        cpu_re = cre; cpu_we = cwe; cpu_addr = ca[15:0]; cpu_wdata = cwd[7:0];
        cird = (pa ^ 8'hA5 ^ (pa >> 8)) & 8'hFF;
        ciram_rdata = cird[7:0];
        #1;
        win  = (((pa >> 12) & 3) == 2);
        slot = (pa >> 10) & 3;
        ofs  = pa & 10'h3FF;
        src  = (m_map >> (2 * slot)) & 3;
        begin
            bit acc, ce, pg, we;
            acc = (prd || pwe) && win;
            ce  = acc && (src < 2);
            pg  = ce && (src == 1);
            we  = ce && pwe;
            chk(ciram_ce === ce, "R2", ciram_ce, ce);
            chk(ciram_page === pg, "R1", ciram_page, pg);
            chk(ciram_we === we, "R8", ciram_we, we);
        end
        if (prd) begin
            if (!win) begin e_ppu = 0; e_ppu_tag = "R11"; end
            else case (src)
                0, 1: begin e_ppu = cird; e_ppu_tag = "R2"; end
                2: begin e_ppu = (m_mode < 2) ? ram[ofs] : 0; e_ppu_tag = "R3"; end
                default: begin
                    e_ppu = (ofs >= 10'h3C0) ? (m_fa * 8'h55) : m_ft;
                    e_ppu_tag = "R4";
                end
            endcase
        end
        if (cre) e_cpu = ((((ca >> 10) & 6'h3F) == 6'h17) && m_mode >= 2) ? ram[ca & 10'h3FF] : 0;
        pxw = pwe && win && (src == 2) && (m_mode < 2);
        if (pxw) ram[ofs] = pwd & 8'hFF;
        else if (cwe && (((ca >> 10) & 6'h3F) == 6'h17) && m_mode != 3) ram[ca & 10'h3FF] = cwd & 8'hFF;
        if (cwe) begin
            if (ca == 16'h5104) m_mode = cwd & 3;
            if (ca == 16'h5105) m_map  = cwd & 8'hFF;
            if (ca == 16'h5106) m_ft   = cwd & 8'hFF;
            if (ca == 16'h5107) m_fa   = cwd & 3;
        end
        @(posedge clk);
        @(negedge clk);
        chk(ppu_rdata === e_ppu[7:0], e_ppu_tag, ppu_rdata, e_ppu);
        chk(cpu_rdata === e_cpu[7:0], "R7", cpu_rdata, e_cpu);
    endtask

    task automatic idle();
        cycle(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic creg(input int a, input int v);
        cycle(0, 0, 0, 0, 0, 1, a, v);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired at %0t", $time);
            summary();
        end
    end

    initial begin
        m_mode = 0; m_map = 0; m_ft = 0; m_fa = 0; e_ppu = 0; e_cpu = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        dir_tag = "R9";
        chk(ppu_rdata === 8'h00, "R9", ppu_rdata, 0);
        chk(cpu_rdata === 8'h00, "R9", cpu_rdata, 0);
        cycle(1, 0, 14'h2C05, 0, 1, 0, 16'h5C10, 0);
        // R6: fill the RAM from the CPU side in mode 2
        dir_tag = "R6";
        creg(16'h5104, 2);
        for (int i = 0; i < 1024; i++) cycle(0, 0, 0, 0, 0, 1, 16'h5C00 + i, (i * 7 + 3) & 8'hFF);
        cycle(0, 0, 0, 0, 1, 0, 16'h5C21, 0);
        creg(16'h5104, 3);
        cycle(0, 0, 0, 0, 0, 1, 16'h5C21, 8'hEE);
        cycle(0, 0, 0, 0, 1, 0, 16'h5C21, 0);
        chk(cpu_rdata === 8'(33 * 7 + 3), "R6", cpu_rdata, (33 * 7 + 3) & 8'hFF);
        // R3: expansion RAM slot visible only in display modes
        dir_tag = "R3";
        creg(16'h5105, 8'hE4);
        cycle(1, 0, 14'h2840, 0, 0, 0, 0, 0);
        creg(16'h5104, 0);
        cycle(1, 0, 14'h2840, 0, 1, 0, 16'h5C40, 0);
        // R4: fill tile and attribute
        dir_tag = "R4";
        creg(16'h5106, 8'h3A);
        creg(16'h5107, 2);
        creg(16'h5105, 8'hFF);
        cycle(1, 0, 14'h2005, 0, 0, 0, 0, 0);
        cycle(1, 0, 14'h27C1, 0, 0, 0, 0, 0);
        cycle(1, 0, 14'h2BBF, 0, 0, 0, 0, 0);
        cycle(0, 1, 14'h2C00, 8'h11, 0, 0, 0, 0);
        // R5: same-cycle map write uses old map
        dir_tag = "R5";
        creg(16'h5105, 8'hE4);
        cycle(1, 0, 14'h2400, 0, 0, 1, 16'h5105, 8'h00);
        cycle(1, 0, 14'h2400, 0, 0, 0, 0, 0);
        // R8: picture processor writes
        dir_tag = "R8";
        creg(16'h5105, 8'hE4);
        cycle(0, 1, 14'h2410, 8'h99, 0, 0, 0, 0);
        cycle(0, 1, 14'h2810, 8'h5D, 0, 0, 0, 0);
        cycle(1, 0, 14'h2810, 0, 0, 0, 0, 0);
        // R10: write collision, picture processor wins
        dir_tag = "R10";
        cycle(0, 1, 14'h2877, 8'hC3, 0, 1, 16'h5C77, 8'h3C);
        creg(16'h5104, 2);
        cycle(0, 0, 0, 0, 1, 0, 16'h5C77, 0);
        chk(cpu_rdata === 8'hC3, "R10", cpu_rdata, 8'hC3);
        // R11: hold and out-of-window
        dir_tag = "R11";
        cycle(1, 0, 14'h1234, 0, 1, 0, 16'h8000, 0);
        idle();
        // random mix
        dir_tag = "R1";
        for (int n = 0; n < 4000; n++) begin
            int r, pa, ca;
            bit prd, pwe, cre, cwe;
            r   = $urandom_range(0, 99);
            pa  = (r < 90) ? (14'h2000 + $urandom_range(0, 4095)) : $urandom_range(0, 16383);
            prd = ($urandom_range(0, 2) != 0);
            pwe = !prd && ($urandom_range(0, 3) == 0);
            cre = ($urandom_range(0, 1) != 0);
            cwe = ($urandom_range(0, 3) == 0);
            r   = $urandom_range(0, 19);
            if (r == 0)      ca = 16'h5104 + $urandom_range(0, 3);
            else if (r < 17) ca = 16'h5C00 + $urandom_range(0, 1023);
            else             ca = $urandom_range(0, 65535);
            cycle(prd, pwe, pa, $urandom_range(0, 255), cre, cwe, ca, $urandom_range(0, 255));
        end
        done = 1;
        summary();
    end
endmodule